// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state update a processor core makes when it takes an exception. A cause code that has already been prioritised arrives with a one-cycle request. From that code the block works out the handler vector, the processor mode to enter, the interrupt-disable bits to set, and the offset to add to the current PC to form the return address. If the high-vector control is on, the vector moves from the low base to the top of the address space.

One clock after an accepted request, the registered outputs hold four values. They are the new PC (the vector), the link value (old PC plus the offset), the saved status (an exact copy of the incoming status word) and the new status word. The new status word has its mode field replaced, the mask bits ORed in and the compressed-instruction bit cleared. In the same cycle a one-cycle flush pulse tells the pipeline to discard in-flight work. A cause code outside the table raises a one-cycle error and leaves every state output unchanged.

The status word layout used throughout is as follows. Bits [4:0] hold the mode. Bit 5 is the compressed-instruction state, bit 6 is the fast-interrupt mask (F), bit 7 is the interrupt mask (I) and bit 8 is the imprecise-abort mask (A). The mode encodings are 0x11 fast-interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort and 0x1B undefined.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs are: pc_o = 0, status_o = 0x1D3 (supervisor mode with A, I and F set), saved_o = 0, link_o = 0, mode_o = 0x13, flush_o = 0 and err_o = 0.
- R2: Each cause code selects a low vector and a mode. The codes map as follows: 0 undefined instruction gives 0x04 and 0x1B; 1 software interrupt gives 0x08 and 0x13; 2 prefetch abort and 3 breakpoint give 0x0C and 0x17; 4 data abort gives 0x10 and 0x17; 5 interrupt gives 0x18 and 0x12; 6 fast interrupt gives 0x1C and 0x11. mode_o equals the selected mode.
- R3: The mask bits ORed into the new status are: I (bit 7) for codes 0 and 1; A and I (bits 8 and 7) for codes 2, 3, 4 and 5; A, I and F (bits 8, 7 and 6) for code 6.
- R4: The return offset is 0 for code 1, 8 for code 4 and 4 for codes 2, 3, 5 and 6. For code 0 it is 2 when cflag_i is high and 4 when it is low.
- R5: When hivec_i is high, 0xFFFF0000 is added to the vector.
- R6: saved_o equals the incoming status word. status_o equals the incoming word with bits [4:0] replaced by the mode, bit 5 cleared and the mask bits set, with all other bits unchanged.
- R7: pc_o becomes the vector and link_o becomes pc_i plus the return offset, both visible one clock after the request.
- R8: flush_o is high for exactly the one cycle after each accepted request. With no request, flush_o is low and all state outputs hold their values.
- R9: A request with cause code 7 sets err_o for one cycle, produces no flush and changes no state output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Exception request strobe |
| cause_i | input | 3 | Prioritised cause code |
| pc_i | input | 32 | Current PC |
| status_i | input | 32 | Current status word |
| cflag_i | input | 1 | Core is in compressed-instruction state |
| hivec_i | input | 1 | High-vector relocation enable |
| pc_o | output | 32 | New PC (handler vector) |
| status_o | output | 32 | New status word |
| saved_o | output | 32 | Saved copy of the old status word |
| link_o | output | 32 | Return address for the link register |
| mode_o | output | 5 | Mode to switch the register banks to |
| flush_o | output | 1 | One-cycle pipeline flush |
| err_o | output | 1 | One-cycle unknown-cause error |

## Verification
Two functions can act on a single entry in the same cycle. The high-vector relocation and the compressed-state return offset both apply when an undefined-instruction request arrives with hivec_i and cflag_i high. The bench provokes this by sweeping every cause across all four combinations of those two inputs. It also issues requests back to back, so that one flush pulse is immediately followed by the next. A behavioural model computes the expected outputs for every cycle, and the bench compares it against each output field separately. A wrong vector base or a wrong offset is therefore reported on its own field.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    CS_UNDEF = 3'd0,
    CS_SWI   = 3'd1,
    CS_PABT  = 3'd2,
    CS_BKPT  = 3'd3,
    CS_DABT  = 3'd4,
    CS_IRQ   = 3'd5,
    CS_FIQ   = 3'd6,
    CS_RSVD  = 3'd7
  } cause_e;

  localparam int MODE_W = 5;
  localparam int VEC_W  = 8;
  localparam int OFF_W  = 4;

  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;

  // status word bit positions
  localparam int BIT_CMP = 5;
  localparam int BIT_F   = 6;
  localparam int BIT_I   = 7;
  localparam int BIT_A   = 8;

  // mask vector order {A, I, F}
  typedef struct packed {
    logic              ok;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
    logic [2:0]        mask;
    logic [OFF_W-1:0]  ret_off;
  } entry_t;

endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
(
  input  cause_e cause,
  input  logic   cflag,
  output entry_t ent
);
  always_comb begin
    ent = '0;
    ent.ok = 1'b1;
    unique case (cause)
      CS_UNDEF: begin
        ent.mode = MD_UND; ent.vec = 8'h04; ent.mask = 3'b010;
        ent.ret_off = cflag ? 4'd2 : 4'd4;
      end
      CS_SWI: begin
        ent.mode = MD_SVC; ent.vec = 8'h08; ent.mask = 3'b010; ent.ret_off = 4'd0;
      end
      CS_PABT, CS_BKPT: begin
        ent.mode = MD_ABT; ent.vec = 8'h0C; ent.mask = 3'b110; ent.ret_off = 4'd4;
      end
      CS_DABT: begin
        ent.mode = MD_ABT; ent.vec = 8'h10; ent.mask = 3'b110; ent.ret_off = 4'd8;
      end
      CS_IRQ: begin
        ent.mode = MD_IRQ; ent.vec = 8'h18; ent.mask = 3'b110; ent.ret_off = 4'd4;
      end
      CS_FIQ: begin
        ent.mode = MD_FIQ; ent.vec = 8'h1C; ent.mask = 3'b111; ent.ret_off = 4'd4;
      end
      default: ent.ok = 1'b0;
    endcase
  end

  // decoded entry for a known cause always carries the I mask
  always_comb begin
    if (ent.ok) assert (ent.mask[1]) else $error("a_r3_i_mask_missing");
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter logic [XLEN-1:0]  HIGH_BASE = 32'hFFFF0000
) (
  input  logic [VEC_W-1:0] vec,
  input  logic             hivec,
  output logic [XLEN-1:0]  target
);
  localparam int PAD_W = XLEN - VEC_W;

  logic [XLEN-1:0] low_vec;
  assign low_vec = {{PAD_W{1'b0}}, vec};
  assign target  = hivec ? (low_vec + HIGH_BASE) : low_vec;
endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   old_st,
  input  logic [MODE_W-1:0] mode,
  input  logic [2:0]        mask,
  output logic [XLEN-1:0]   new_st
);
  always_comb begin
    new_st = old_st;
    new_st[MODE_W-1:0] = mode;
    new_st[BIT_CMP]    = 1'b0;
    new_st[BIT_A]      = old_st[BIT_A] | mask[2];
    new_st[BIT_I]      = old_st[BIT_I] | mask[1];
    new_st[BIT_F]      = old_st[BIT_F] | mask[0];
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFFF0000,
  parameter logic [XLEN-1:0] RESET_PC  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [2:0]        cause_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic              cflag_i,
  input  logic              hivec_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   saved_o,
  output logic [XLEN-1:0]   link_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              flush_o,
  output logic              err_o
);
  localparam logic [XLEN-1:0] RESET_ST =
    XLEN'(MD_SVC) | (XLEN'(1) << BIT_A) | (XLEN'(1) << BIT_I) | (XLEN'(1) << BIT_F);

  entry_t          ent;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] next_st;
  logic [XLEN-1:0] next_link;
  logic            take;

  exc_decode u_dec (
    .cause (cause_e'(cause_i)),
    .cflag (cflag_i),
    .ent   (ent)
  );

  exc_vector #(.XLEN(XLEN), .HIGH_BASE(HIGH_BASE)) u_vec (
    .vec    (ent.vec),
    .hivec  (hivec_i),
    .target (target)
  );

  exc_status #(.XLEN(XLEN)) u_st (
    .old_st (status_i),
    .mode   (ent.mode),
    .mask   (ent.mask),
    .new_st (next_st)
  );

  assign next_link = pc_i + XLEN'(ent.ret_off);
  assign take      = req_i & ent.ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o     <= RESET_PC;
      status_o <= RESET_ST;
      saved_o  <= '0;
      link_o   <= '0;
      mode_o   <= MD_SVC;
      flush_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      flush_o <= take;
      err_o   <= req_i & ~ent.ok;
      if (take) begin
        pc_o     <= target;
        status_o <= next_st;
        saved_o  <= status_i;
        link_o   <= next_link;
        mode_o   <= ent.mode;
      end
    end
  end

  // R8: an accepted request flushes the next cycle
  a_r8_flush_follows: assert property (@(posedge clk) disable iff (rst)
    (req_i && cause_i != 3'd7) |=> flush_o);
  // R9: error never coincides with flush and leaves state untouched
  a_r9_err_no_flush: assert property (@(posedge clk) disable iff (rst)
    !(err_o && flush_o));
  a_r9_err_holds: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($stable(pc_o) && $stable(status_o) && $stable(link_o) && $stable(saved_o)));
  // R6: saved copy is the status presented with the request
  a_r6_saved_copy: assert property (@(posedge clk) disable iff (rst)
    req_i && cause_i != 3'd7 |=> saved_o == $past(status_i));
  // R6: new status leaves compressed state and always masks IRQ
  a_r6_cmp_clear: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (!status_o[BIT_CMP] && status_o[BIT_I]));
  // R2: mode request agrees with the status mode field
  a_r2_mode_match: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> status_o[MODE_W-1:0] == mode_o);
  // R8: idle cycles hold state
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!flush_o && $stable(pc_o) && $stable(mode_o)));
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [2:0]  cause_i = '0;
  logic [31:0] pc_i = '0, status_i = '0;
  logic        cflag_i = 1'b0, hivec_i = 1'b0;
  logic [31:0] pc_o, status_o, saved_o, link_o;
  logic [4:0]  mode_o;
  logic        flush_o, err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] e_pc, e_st, e_sv, e_lk;
  logic [4:0]  e_md;
  logic        e_fl, e_er;

  always #2 clk = ~clk;

  exc_entry_seq u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .cause_i(cause_i), .pc_i(pc_i),
    .status_i(status_i), .cflag_i(cflag_i), .hivec_i(hivec_i),
    .pc_o(pc_o), .status_o(status_o), .saved_o(saved_o), .link_o(link_o),
    .mode_o(mode_o), .flush_o(flush_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    chk({ctx, " pc R2/R5/R7"}, pc_o, e_pc);
    chk({ctx, " status R3/R6"}, status_o, e_st);
    chk({ctx, " saved R6"}, saved_o, e_sv);
    chk({ctx, " link R4/R7"}, link_o, e_lk);
    chk({ctx, " mode R2"}, {27'd0, mode_o}, {27'd0, e_md});
    chk({ctx, " flush R8"}, {31'd0, flush_o}, {31'd0, e_fl});
    chk({ctx, " err R9"}, {31'd0, err_o}, {31'd0, e_er});
  endtask

  // behavioural reference: one cycle of the block
  task automatic model(input logic rq, input int c, input logic [31:0] pc,
                       input logic [31:0] st, input logic cf, input logic hv);
    logic [31:0] v, mk; logic [4:0] m; int off; bit known;
    known = 1; v = 0; mk = 0; m = 0; off = 0;
    case (c)
      0: begin v = 32'h04; m = 5'h1B; mk = 32'h080; off = cf ? 2 : 4; end
      1: begin v = 32'h08; m = 5'h13; mk = 32'h080; off = 0; end
      2, 3: begin v = 32'h0C; m = 5'h17; mk = 32'h180; off = 4; end
      4: begin v = 32'h10; m = 5'h17; mk = 32'h180; off = 8; end
      5: begin v = 32'h18; m = 5'h12; mk = 32'h180; off = 4; end
      6: begin v = 32'h1C; m = 5'h11; mk = 32'h1C0; off = 4; end
      default: known = 0;
    endcase
    e_fl = rq && known;
    e_er = rq && !known;
    if (rq && known) begin
      e_pc = hv ? v + 32'hFFFF0000 : v;
      e_st = (st & ~32'h3F) | {27'd0, m} | mk;
      e_sv = st;
      e_lk = pc + off;
      e_md = m;
    end
  endtask

  task automatic step(input logic rq, input int c, input logic [31:0] pc,
                      input logic [31:0] st, input logic cf, input logic hv, input string ctx);
    req_i = rq; cause_i = c[2:0]; pc_i = pc; status_i = st; cflag_i = cf; hivec_i = hv;
    model(rq, c, pc, st, cf, hv);
    @(posedge clk); @(negedge clk);
    compare_all(ctx);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    report();
  end

  initial begin
    e_pc = 0; e_st = 32'h1D3; e_sv = 0; e_lk = 0; e_md = 5'h13; e_fl = 0; e_er = 0;
    repeat (2) @(negedge clk);
    compare_all("reset R1");
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, "post-reset R1");
    // sweep causes across compressed and high-vector combinations
    for (int hv = 0; hv < 2; hv++)
      for (int cf = 0; cf < 2; cf++)
        for (int c = 0; c < 8; c++) begin
          step(1, c, 32'h0000_1000 + c * 16, 32'h6000_0030 | (cf << 5) | c, cf[0], hv[0], "sweep");
          step(0, c, 32'hDEAD_0000, 32'hFFFF_FFFF, 1, 1, "idle R8");
        end
    // unknown cause right after an accept: state must stay
    step(1, 4, 32'h8000_0000, 32'h0000_0010, 0, 0, "dabt R4");
    step(1, 7, 32'h1234_5678, 32'hFFFF_FFFF, 1, 1, "bad cause R9");
    step(1, 7, 32'h0, 32'h0, 0, 0, "bad cause again R9");
    // status bits above the masks pass through; masks already set stay set
    step(1, 1, 32'hFFFF_FFFE, 32'hF0F0_F1FF, 0, 0, "swi wrap R6");
    // back-to-back random entries
    for (int k = 0; k < 300; k++)
      step(($urandom % 4) != 0, $urandom % 8, $urandom, $urandom,
           $urandom % 2, $urandom % 2, "random");
    // reset mid-stream restores R1 values
    rst = 1'b1;
    e_pc = 0; e_st = 32'h1D3; e_sv = 0; e_lk = 0; e_md = 5'h13; e_fl = 0; e_er = 0;
    req_i = 1'b1; cause_i = 3'd6;
    @(posedge clk); @(negedge clk);
    compare_all("re-reset R1");
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, "end idle R8");
    report();
  end
endmodule